// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one request from a processor core into one complete memory or I/O bus cycle on a set of shared address/data lines. The requester supplies an address, write data, a direction bit and a memory/I/O select. The sequencer then steps through four fixed phases, T1 to T4. In T1 it drives the address and pulses an address latch strobe. In the middle phases it drives the active-low read or write strobe and the data buffer enable. In T4 it releases all strobes.

A slow target can stretch the cycle by holding READY low. READY is sampled at the clock edge that ends T2. If it is low, wait phases are inserted before T3. Inside each wait phase READY is sampled again at the falling clock edge, and T3 follows once that sample is high. For a read, the data on the shared lines is captured on the edge that enters T4. It is returned with a one-cycle done pulse. A new request may start in idle or be chained directly from T4 into the next T1.

Top module: `busCycleSeq`

## Requirements
- R1: After reset the bus is idle: `ale` 0, `rdN`/`wrN`/`denN` 1, `adOe` 0, `dtR` 1, `ioSel` 0, `doneValid` 0 and `reqReady` 1.
- R2: A request with `reqValid` high while `reqReady` is high is taken on that clock edge. The next cycle is T1, in which `adOe` is 1, `adOut` carries the address, `dtR` equals `reqWrite` (1 transmit, 0 receive) and `ioSel` equals `reqIo` (1 I/O, 0 memory). `dtR` and `ioSel` hold these values through T4.
- R3: `ale` is high for exactly one cycle per bus cycle (T1) and low in every other phase.
- R4: For a write, `wrN` and `denN` are low from T2 through T3, including every wait phase. Throughout that span `adOe` is 1, `adOut` is the write data on bits [DATA_W-1:0] with zeros above, and `rdN` stays 1.
- R5: For a read, `rdN` and `denN` are low from T2 through T3, including every wait phase. Throughout that span `adOe` is 0 and `wrN` stays 1.
- R6: If READY is high at the edge that ends T2, the cycle takes exactly four clocks, with the strobes low for two of them.
- R7: If READY is low at the edge that ends T2, one wait phase is inserted for each wait phase whose falling-edge READY sample is low. READY rising only after that falling edge still costs one more wait phase.
- R8: Read data is the value of `adIn` at the edge entering T4; it appears on `doneRdata` with `doneValid` high for the single T4 cycle.
- R9: In T4 `ale` is 0, `rdN`/`wrN`/`denN` are 1, `adOe` is 0 and `reqReady` is 1. A request taken at the end of T4 goes straight to T1 with no idle cycle.
- R10: `reqReady` is 0 from T1 through T3, so a `reqValid` pulse in those phases starts no bus cycle and does not change the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | ADDR_W | Bus cycle address |
| reqWdata | input | DATA_W | Write data |
| reqWrite | input | 1 | 1 write, 0 read |
| reqIo | input | 1 | 1 I/O space, 0 memory space |
| reqReady | output | 1 | Request can be taken this cycle |
| doneValid | output | 1 | One-cycle pulse in T4 |
| doneRdata | output | DATA_W | Captured read data |
| adOut | output | ADDR_W | Value driven on shared lines |
| adOe | output | 1 | Output enable for shared lines |
| adIn | input | DATA_W | Data lines read back from bus |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| dtR | output | 1 | Direction: 1 transmit, 0 receive |
| denN | output | 1 | Data buffer enable, active low |
| ioSel | output | 1 | Memory/I/O select |
| ready | input | 1 | Target ready, low inserts wait phases |

## Verification
The bench builds the block with its defaults, ADDR_W 20 and DATA_W 16. The four upper shared lines are then zero in the data phase, so an address left on the lines in place of data is caught. Read data changes as T4 begins, so a capture taken one edge late reads wrong data. The wait-phase cases include one where READY rises after the falling edge of a wait phase. That case tells a falling-edge sample from a rising-edge sample by the length of the strobe.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_WAIT = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef struct packed {
    logic load;
    logic ale;
    logic driveAddr;
    logic driveData;
    logic rdStb;
    logic wrStb;
    logic bufEn;
    logic capture;
    logic done;
    logic active;
  } busStrobes_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        ready,
  input  logic        curWrite,
  output logic        reqReady,
  output busStrobes_t stb
);

  phase_e phase;
  phase_e phaseNext;
  logic   readyMid;
  logic   strobePhase;

  // second READY sample, taken at the falling edge inside a wait phase
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) readyMid <= 1'b0;
    else       readyMid <= ready;
  end

  assign reqReady = (phase == PH_IDLE) || (phase == PH_T4);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (reqValid) phaseNext = PH_T1;
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = ready ? PH_T3 : PH_WAIT;
      PH_WAIT: phaseNext = readyMid ? PH_T3 : PH_WAIT;
      PH_T3:   phaseNext = PH_T4;
      PH_T4:   phaseNext = reqValid ? PH_T1 : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign strobePhase = (phase == PH_T2) || (phase == PH_WAIT) || (phase == PH_T3);

  always_comb begin
    stb           = '0;
    stb.load      = reqReady && reqValid;
    stb.ale       = (phase == PH_T1);
    stb.driveAddr = (phase == PH_T1);
    stb.driveData = strobePhase && curWrite;
    stb.rdStb     = strobePhase && !curWrite;
    stb.wrStb     = strobePhase && curWrite;
    stb.bufEn     = strobePhase;
    stb.capture   = (phase == PH_T3);
    stb.done      = (phase == PH_T4);
    stb.active    = (phase != PH_IDLE);
  end

  AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (phase == PH_T1)); // R2
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T1) |=> (phase != PH_T1)); // R3
  AST_T2_NOWAIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T2 && ready) |=> (phase == PH_T3)); // R6
  AST_T2_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T2 && !ready) |=> (phase == PH_WAIT)); // R7
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T1 || phase == PH_T2 || phase == PH_WAIT || phase == PH_T3) |-> !reqReady); // R10

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [DATA_W-1:0] adIn,
  output logic              curWrite,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic              dtR,
  output logic              ioSel,
  output logic [DATA_W-1:0] doneRdata
);

  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              writeQ;
  logic              ioQ;
  logic [DATA_W-1:0] rdataQ;
  logic [ADDR_W-1:0] dataWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
    end else if (stb.load) begin
      addrQ  <= reqAddr;
      dataQ  <= reqWdata;
      writeQ <= reqWrite;
      ioQ    <= reqIo;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdataQ <= '0;
    else if (stb.capture) rdataQ <= adIn;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign dataWide = {{PAD_W{1'b0}}, dataQ};
    end else begin : g_nopad
      assign dataWide = dataQ[ADDR_W-1:0];
    end
  endgenerate

  assign curWrite  = writeQ;
  assign adOut     = stb.driveAddr ? addrQ : dataWide;
  assign adOe      = stb.driveAddr || stb.driveData;
  assign dtR       = !(stb.active && !writeQ);
  assign ioSel     = stb.active && ioQ;
  assign doneRdata = rdataQ;

  AST_CAPTURE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (doneRdata == $past(adIn))); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.active && !stb.load) |=> $stable(addrQ)); // R2

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic              reqIo,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRdata,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              dtR,
  output logic              denN,
  output logic              ioSel,
  input  logic              ready
);

  busStrobes_t stb;
  logic        curWrite;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .curWrite (curWrite),
    .reqReady (reqReady),
    .stb      (stb)
  );

  busSeqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqWrite  (reqWrite),
    .reqIo     (reqIo),
    .adIn      (adIn),
    .curWrite  (curWrite),
    .adOut     (adOut),
    .adOe      (adOe),
    .dtR       (dtR),
    .ioSel     (ioSel),
    .doneRdata (doneRdata)
  );

  assign ale       = stb.ale;
  assign rdN       = !stb.rdStb;
  assign wrN       = !stb.wrStb;
  assign denN      = !stb.bufEn;
  assign doneValid = stb.done;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe); // R4
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!denN) ##1 denN |-> doneValid); // R9

endmodule

// File: tb/busCycleSeq_tb.sv
`timescale 1ns/1ps
module busCycleSeq_tb;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam time CLK_PERIOD = 20ns;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              write;
    logic              io;
    int                waits;
    logic [DATA_W-1:0] rdata;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqWrite = 1'b0;
  logic              reqIo = 1'b0;
  logic              reqReady;
  logic              doneValid;
  logic [DATA_W-1:0] doneRdata;
  logic [ADDR_W-1:0] adOut;
  logic              adOe;
  logic [DATA_W-1:0] adIn = '0;
  logic              ale, rdN, wrN, dtR, denN, ioSel;
  logic              ready = 1'b1;

  item_t             expQ[$];
  int                vectors = 0;
  int                miscompares = 0;
  int                issued = 0;
  int                aleCount = 0;
  int                curWaits = 0;
  bit                curLate = 1'b0;
  logic [DATA_W-1:0] curRdata = '0;
  int                lowIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqReady(reqReady), .doneValid(doneValid), .doneRdata(doneRdata),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .ale(ale), .rdN(rdN),
    .wrN(wrN), .dtR(dtR), .denN(denN), .ioSel(ioSel), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // target model: READY, and read data that is only valid while a strobe is low
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (!rdN || !wrN) lowIdx++;
      else              lowIdx = 0;
      adIn = (!rdN) ? curRdata : 16'hDEAD;
      if (lowIdx == 0) ready = 1'b1;
      else begin
        if ((lowIdx - 1) >= curWaits) begin
          if (curLate && lowIdx > 1 && !ready) begin
            #10;
            ready = 1'b1;   // rises after the mid-phase sample
          end else ready = 1'b1;
        end else ready = 1'b0;
      end
    end
  end

  task automatic issue(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic w, input logic io, input int waits,
                       input bit late, input logic [DATA_W-1:0] rd);
    item_t it;
    while (!reqReady) begin
      @(posedge clk);
      #3;
    end
    curWaits = waits;
    curLate  = late;
    curRdata = rd;
    it.addr = a; it.data = d; it.write = w; it.io = io;
    it.waits = late ? waits + 1 : waits;
    it.rdata = rd;
    expQ.push_back(it);
    issued++;
    reqValid = 1'b1; reqAddr = a; reqWdata = d; reqWrite = w; reqIo = io;
    @(posedge clk);
    #3;
    reqValid = 1'b0;
  endtask

  // monitor: pops the expected item when a T1 phase appears and follows it to T4
  initial begin
    item_t it;
    int    lowCnt;
    @(posedge rstN);
    forever begin
      @(posedge clk);
      #12;
      if (ale) begin
        aleCount++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected bus cycle", 32'(adOut), 32'h0);
        end else begin
          it = expQ.pop_front();
          chk(adOe == 1'b1, "R2", "T1 adOe", 32'(adOe), 32'h1);
          chk(adOut == it.addr, "R2", "T1 address", 32'(adOut), 32'(it.addr));
          chk(dtR == it.write, "R2", "T1 dtR", 32'(dtR), 32'(it.write));
          chk(ioSel == it.io, "R2", "T1 ioSel", 32'(ioSel), 32'(it.io));
          chk(rdN && wrN && denN, "R3", "T1 strobes idle", {29'd0, rdN, wrN, denN}, 32'h7);
          lowCnt = 0;
          @(posedge clk);
          #12;
          while (!rdN || !wrN) begin
            lowCnt++;
            chk(!ale, "R3", "ale outside T1", 32'(ale), 32'h0);
            chk(!denN, "R4", "denN in strobe span", 32'(denN), 32'h0);
            chk(dtR == it.write && ioSel == it.io, "R2", "dtR/ioSel hold",
                {30'd0, dtR, ioSel}, {30'd0, it.write, it.io});
            if (it.write) begin
              chk(!wrN && rdN, "R4", "write strobes", {30'd0, rdN, wrN}, 32'h2);
              chk(adOe && adOut == ADDR_W'(it.data), "R4", "write data on lines",
                  32'(adOut), 32'(it.data));
            end else begin
              chk(!rdN && wrN, "R5", "read strobes", {30'd0, rdN, wrN}, 32'h1);
              chk(!adOe, "R5", "read lines released", 32'(adOe), 32'h0);
            end
            @(posedge clk);
            #12;
          end
          if (curLate && !it.write)
            chk(lowCnt == it.waits + 2, "R7", "late READY strobe length", 32'(lowCnt), 32'(it.waits + 2));
          else if (it.waits == 0)
            chk(lowCnt == 2, "R6", "no-wait strobe length", 32'(lowCnt), 32'd2);
          else
            chk(lowCnt == it.waits + 2, "R7", "wait strobe length", 32'(lowCnt), 32'(it.waits + 2));
          chk(doneValid, "R9", "T4 done", 32'(doneValid), 32'h1);
          chk(!ale && rdN && wrN && denN && !adOe, "R9", "T4 idle strobes",
              {27'd0, ale, rdN, wrN, denN, adOe}, 32'hE);
          chk(reqReady, "R9", "T4 reqReady", 32'(reqReady), 32'h1);
          chk(dtR == it.write, "R2", "T4 dtR", 32'(dtR), 32'(it.write));
          if (!it.write)
            chk(doneRdata == it.rdata, "R8", "read data", 32'(doneRdata), 32'(it.rdata));
        end
      end else if (doneValid) begin
        chk(1'b0, "R9", "done without cycle", 32'(doneValid), 32'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    chk(1'b0, "ALL", "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    rstN = 1'b1;
    @(posedge clk);
    #12;
    // R1 reset state
    chk(!ale && rdN && wrN && denN && !adOe, "R1", "idle strobes",
        {27'd0, ale, rdN, wrN, denN, adOe}, 32'hE);
    chk(dtR && !ioSel, "R1", "idle dtR/ioSel", {30'd0, dtR, ioSel}, 32'h2);
    chk(!doneValid && reqReady, "R1", "idle done/reqReady",
        {30'd0, doneValid, reqReady}, 32'h1);
    @(posedge clk);
    #3;

    issue(20'h12345, 16'hA55A, 1'b1, 1'b0, 0, 1'b0, 16'h0);   // R6 write
    issue(20'h00F80, 16'h0000, 1'b0, 1'b1, 0, 1'b0, 16'h3C96); // R6 read, I/O
    issue(20'hABCDE, 16'h0F0F, 1'b1, 1'b1, 2, 1'b0, 16'h0);   // R7 write waits
    issue(20'h54321, 16'h0000, 1'b0, 1'b0, 3, 1'b0, 16'hBEEF); // R7 read waits
    issue(20'h0FFFF, 16'h0000, 1'b0, 1'b0, 1, 1'b1, 16'h1234); // R7 late READY
    issue(20'hFFFFF, 16'hFFFF, 1'b1, 1'b0, 0, 1'b0, 16'h0);   // R9 chained
    issue(20'h00001, 16'h0000, 1'b0, 1'b0, 0, 1'b0, 16'h8001);
    issue(20'h80000, 16'h7FFE, 1'b1, 1'b1, 1, 1'b0, 16'h0);

    // R10: a request pulse in T2/Tw must be ignored
    issue(20'h22222, 16'h1111, 1'b1, 1'b0, 1, 1'b0, 16'h0);
    @(posedge clk);
    #3;
    reqValid = 1'b1; reqAddr = 20'h99999; reqWdata = 16'h6666; reqWrite = 1'b0;
    @(posedge clk);
    #3;
    reqValid = 1'b0;

    repeat (12) @(posedge clk);
    #12;
    chk(aleCount == issued, "R10", "bus cycles started", 32'(aleCount), 32'(issued));
    chk(expQ.size() == 0, "R2", "all requests completed", 32'(expQ.size()), 32'h0);
    chk(!ale && rdN && wrN && reqReady, "R1", "returns to idle",
        {28'd0, ale, rdN, wrN, reqReady}, 32'h7);
    summary();
    $finish;
  end

endmodule